// File: doc/BRIEF.md
# Reloadable Refresh Watchdog Timer

This block watches for a periodic refresh. Each arm strobe loads a down-counter with a reload value that arrives on the same cycle. A slow tick, nominally every 20 ms, takes one off the count. If the count runs out before the next arm strobe arrives, the block raises a fault flag and holds it there. A later arm strobe clears the flag and starts a fresh countdown from its own reload value.

The tick can come from outside the block on a strobe input. Setting `TICK_DIV` to a non-zero value selects the other option: a free-running prescaler inside the block divides the system clock and makes the tick. The reset input is asynchronous and active-low. Its release is synchronised to the clock inside the block.

Top module: `refresh_wdog`

## Requirements
- R1: In the cycle after an arm strobe, the fault flag is low and the counter holds the reload value that came with that strobe.
- R2: An arm strobe during a countdown that is still running abandons it. The fault then follows the new reload value only.
- R3: Each tick that arrives during a countdown, without an arm strobe in the same cycle, lowers the counter by exactly one.
- R4: With a reload value N greater than zero and no further arm strobe, the fault flag rises on the clock edge that samples the Nth tick after the arm. It does not rise on an edge without a tick.
- R5: Once raised, the fault flag stays high and further ticks change nothing, until an arm strobe or a reset.
- R6: When an arm strobe and a tick arrive in the same cycle, the arm wins and that tick does not count.
- R7: A reload value of zero raises the fault on the first tick after the arm.
- R8: After reset the fault flag is low and the timer is idle. Ticks leave the fault low until the first arm strobe.
- R9: With `TICK_DIV` = D > 0, the internal tick is a one-cycle pulse every D clock cycles and the `tick_i` input is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| arm_i | input | 1 | Arm/refresh strobe, one cycle per event |
| reload_i | input | CNT_W | Countdown value taken with each arm strobe |
| tick_i | input | 1 | External tick strobe (used when TICK_DIV = 0) |
| fault_o | output | 1 | Refresh-lost flag, registered and sticky |

## Verification
The fault flag comes from a register. Any change caused by an arm strobe or a tick shows on `fault_o` one clock edge after the cycle that presents it. The bench drives every vector on a falling edge and compares the flag on the next falling edge, which is exactly one register stage later. After reset is released, the synchroniser takes two edges, so the bench waits past them before its first vector. For the internal prescaler, the tick phase is free-running. The bench therefore counts edges from the arm strobe to the fault and accepts only the window of D edges that the divider allows for the chosen reload value.

// File: rtl/refresh_wdog_pkg.sv
package refresh_wdog_pkg;

  typedef enum logic [1:0] {
    WD_IDLE  = 2'b00,
    WD_RUN   = 2'b01,
    WD_FAULT = 2'b10
  } wd_state_e;

endpackage

// File: rtl/wdog_rst_sync.sv
module wdog_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_no = chain_q[STAGES-1];

endmodule

// File: rtl/wdog_tick_div.sv
module wdog_tick_div #(
  parameter int unsigned DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);

  localparam int unsigned DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(DIV - 1);

  logic [DW-1:0] div_q;
  logic [DW-1:0] div_d;
  logic          wrap;

  assign wrap = (div_q == LAST);

  always_comb begin
    div_d = wrap ? '0 : div_q + DW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
    end else begin
      div_q <= div_d;
    end
  end

  assign tick_o = wrap;

  generate
    if (DIV > 1) begin : g_pulse_chk
      // R9
      tick_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate

endmodule

// File: rtl/wdog_countdown.sv
module wdog_countdown
  import refresh_wdog_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             tick_i,
  output logic             fault_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  wd_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             fault_q, fault_d;
  logic             run_tick;
  logic             upd_en;

  assign run_tick = tick_i && (state_q == WD_RUN) && !arm_i;
  assign upd_en   = arm_i || run_tick;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (arm_i) begin
      state_d = WD_RUN;
      cnt_d   = reload_i;
    end else if (run_tick) begin
      if (cnt_q <= ONE) begin
        state_d = WD_FAULT;
        cnt_d   = '0;
      end else begin
        cnt_d   = cnt_q - ONE;
      end
    end
    fault_d = (state_d == WD_FAULT);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WD_IDLE;
      cnt_q   <= '0;
      fault_q <= 1'b0;
    end else if (upd_en) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      fault_q <= fault_d;
    end
  end

  assign fault_o = fault_q;

  // R1
  arm_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> (cnt_q == $past(reload_i)) && !fault_q);

  // R3
  step_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !arm_i && state_q == WD_RUN && cnt_q > ONE)
      |=> cnt_q == ($past(cnt_q) - ONE));

  // R4
  fault_needs_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_q) |-> $past(tick_i && !arm_i));

  // R5
  fault_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_q && !arm_i) |=> fault_q);

  // R8
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == WD_IDLE) |-> !fault_q);

  // R8
  idle_stay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == WD_IDLE && !arm_i) |=> state_q == WD_IDLE);

endmodule

// File: rtl/refresh_wdog.sv
module refresh_wdog #(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned TICK_DIV = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             tick_i,
  output logic             fault_o
);

  logic rst_n_sync;
  logic tick_sel;

  wdog_rst_sync #(
    .STAGES(2)
  ) u_rst_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rst_sync_no(rst_n_sync)
  );

  generate
    if (TICK_DIV == 0) begin : g_ext_tick
      assign tick_sel = tick_i;
    end else begin : g_int_tick
      logic unused_tick_in;
      assign unused_tick_in = tick_i;
      wdog_tick_div #(
        .DIV(TICK_DIV)
      ) u_tick_div (
        .clk_i (clk_i),
        .rst_ni(rst_n_sync),
        .tick_o(tick_sel)
      );
    end
  endgenerate

  wdog_countdown #(
    .CNT_W(CNT_W)
  ) u_countdown (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_sync),
    .arm_i   (arm_i),
    .reload_i(reload_i),
    .tick_i  (tick_sel),
    .fault_o (fault_o)
  );

endmodule

// File: tb/refresh_wdog_tb_top.sv
module refresh_wdog_tb_top;

  localparam int CW = 8;
  localparam int NV = 22;
  // {arm, tick, reload[7:0], expected fault after the edge}
  localparam logic [10:0] VEC [0:NV-1] = '{
    {1'b0, 1'b1, 8'd0,   1'b0},  // R8 tick while idle
    {1'b0, 1'b1, 8'd0,   1'b0},  // R8
    {1'b1, 1'b0, 8'd3,   1'b0},  // R1 arm 3
    {1'b0, 1'b1, 8'd0,   1'b0},  // R3 ->2
    {1'b0, 1'b0, 8'd0,   1'b0},
    {1'b0, 1'b1, 8'd0,   1'b0},  // ->1
    {1'b0, 1'b1, 8'd0,   1'b1},  // R4 third tick
    {1'b0, 1'b1, 8'd0,   1'b1},  // R5
    {1'b0, 1'b0, 8'd0,   1'b1},  // R5
    {1'b1, 1'b1, 8'd2,   1'b0},  // R6 arm+tick
    {1'b0, 1'b1, 8'd0,   1'b0},  // R6 ->1
    {1'b1, 1'b0, 8'd3,   1'b0},  // R2 restart 3
    {1'b0, 1'b1, 8'd0,   1'b0},  // R2
    {1'b0, 1'b1, 8'd0,   1'b0},  // R2
    {1'b0, 1'b1, 8'd0,   1'b1},  // R2 fault
    {1'b1, 1'b0, 8'd0,   1'b0},  // R7 arm 0
    {1'b0, 1'b0, 8'd0,   1'b0},  // R7
    {1'b0, 1'b1, 8'd0,   1'b1},  // R7 first tick
    {1'b1, 1'b0, 8'd1,   1'b0},  // R1 arm 1
    {1'b0, 1'b1, 8'd0,   1'b1},  // R4 N=1
    {1'b1, 1'b0, 8'd255, 1'b0},  // R1 arm max
    {1'b0, 1'b1, 8'd0,   1'b0}   // R3
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          arm = 1'b0;
  logic [CW-1:0] reload = '0;
  logic          tick = 1'b0;
  logic          fault;
  logic          p_arm = 1'b0;
  logic [CW-1:0] p_reload = '0;
  logic          p_fault;
  int            total = 0;
  int            bad = 0;
  bit            done = 1'b0;

  always #10 clk = ~clk;

  refresh_wdog #(.CNT_W(CW), .TICK_DIV(0)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .arm_i(arm), .reload_i(reload),
    .tick_i(tick), .fault_o(fault)
  );

  refresh_wdog #(.CNT_W(CW), .TICK_DIV(4)) dut_pre_i (
    .clk_i(clk), .rst_ni(rst_n), .arm_i(p_arm), .reload_i(p_reload),
    .tick_i(1'b1), .fault_o(p_fault)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic a, input logic t, input logic [CW-1:0] v);
    arm = a; tick = t; reload = v;
    @(negedge clk);
    arm = 1'b0; tick = 1'b0; reload = '0;
  endtask

  task automatic pre_measure(input logic [CW-1:0] v, output int n);
    p_arm = 1'b1; p_reload = v;
    @(negedge clk);
    p_arm = 1'b0;
    n = 0;
    while (!p_fault && n < 40) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk("R8 fault in reset", fault, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R8 fault after reset", fault, 0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][10], VEC[i][9], VEC[i][8:1]);
      chk($sformatf("vector %0d R1..R8 table", i), fault, VEC[i][0]);
    end

    // R3 / R4: reload 5, one tick per cycle, count ticks to fault
    drive(1'b1, 1'b0, 8'd5);
    n = 0;
    while (!fault && n < 20) begin
      drive(1'b0, 1'b1, 8'd0);
      n++;
    end
    chk("R3 ticks to fault for reload 5", n, 5);

    // R5: fault held across idle cycles and ticks
    repeat (3) drive(1'b0, 1'b0, 8'd0);
    chk("R5 hold idle", fault, 1);

    // R8: reset in the middle clears the fault and ticks stay ignored
    rst_n = 1'b0;
    @(negedge clk);
    chk("R8 async clear", fault, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    repeat (3) drive(1'b0, 1'b1, 8'd0);
    chk("R8 ticks before arm", fault, 0);

    // R9: internal prescaler, divider 4
    pre_measure(8'd2, n);
    chk("R9 reload 2 window lo", int'(n >= 5), 1);
    chk("R9 reload 2 window hi", int'(n <= 8), 1);
    pre_measure(8'd4, n);
    chk("R9 reload 4 window lo", int'(n >= 13), 1);
    chk("R9 reload 4 window hi", int'(n <= 16), 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule